// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block is the device end of a byte-wide SPI link into a switch-style register map that is split into blocks and subblocks. The host opens a frame by pulling chip select low. Its first byte names the target block, the subblock and the direction. Its second byte names the register. A write frame then carries a 32-bit word. A read frame carries two filler bytes, and during the four bytes after them the block shifts the 32-bit read word out. The port turns each complete frame into a single-cycle strobe on a simple register bus. The strobe carries the block, subblock, register address and, for writes, the data word. For reads, the port takes the returned word back from the register bus.

All serial inputs are brought into the system clock through a short synchronizer. Edges of the serial clock are detected there. The serial clock must therefore run several times slower than the system clock. The register bus has no back-pressure: the serial timing cannot be stalled. The register side must accept a strobe in the cycle it appears, and it must hold read data stable from the read strobe until the end of the second filler byte. Any access to a block/subblock pair that does not exist is suppressed and raises a sticky error flag.

Top module: `spireg_port`

## Requirements
- R1: SPI mode 0 is used. The block samples MOSI on rising serial-clock edges, MSB first, in 8-bit units. In the first byte of a frame, bits [7:5] are the block number, bit 4 is the direction (1 = write, 0 = read) and bits [3:0] are the subblock number. These fields appear on `reg_blk`, `reg_we` and `reg_sub` with the strobe.
- R2: The second byte of a frame is the register address and appears on `reg_addr` with the strobe.
- R3: A write frame is 6 bytes: command, register, then four data bytes with the most significant byte first. After the last data bit, exactly one strobe is issued with `reg_we`=1 and `reg_wdata` equal to the assembled word.
- R4: A read frame is command, register, two filler bytes, then four bytes driven on MISO with the most significant byte first. A strobe with `reg_we`=0 is issued after the register byte. `reg_rdata` is captured at the end of the second filler byte. Each MISO bit is stable at the rising edge where the host samples it.
- R5: The legal pairs are block 1 with subblocks 0–4 or 6, block 2 or 7 with subblock 0, and block 3, 4 or 5 with subblock 0 or 1. Accesses to legal pairs never set the error flag.
- R6: An access to any other pair issues no strobe. A read of such a pair returns all zeros on MISO. Either kind of access sets `err_flag`, which stays set until reset.
- R7: Raising chip select mid-frame discards the partial frame without a strobe, and the next frame starts again at its first byte. With chip select high, the block issues no strobe and MISO is low.
- R8: The strobe is one system-clock cycle wide and appears at most once per frame.
- R9: After reset, `reg_req`, `err_flag` and `spi_miso` are low.
- R10: Bytes after the end of a frame have no effect. No further strobe is issued, and a read returns zeros after its four data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the host |
| reg_req | output | 1 | One-cycle register access strobe |
| reg_we | output | 1 | Direction of the access, 1 = write |
| reg_blk | output | 3 | Target block |
| reg_sub | output | 4 | Target subblock |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 32 | Write word |
| reg_rdata | input | 32 | Read word returned by the register side |
| err_flag | output | 1 | Sticky flag for accesses to illegal pairs |

## Verification
The bench uses the default parameters: two synchronizer stages, two filler bytes and four data bytes. With these values, the 3-bit block and 4-bit subblock fields span only 128 pairs. Every one of those pairs is driven through both a complete write frame and a read frame that runs past its end. This covers every legal and illegal pair, the data assembly and the MISO shift-out. The serial clock runs at six system clocks per period, which puts the synchronizer latency and the read-data capture point inside a single half period. Aborted frames, including one cut off mid-byte, check that framing restarts at the first byte.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

  localparam int BLK_W  = 3;
  localparam int SUB_W  = 4;
  localparam int UNIT_W = 8;

  typedef struct packed {
    logic [BLK_W-1:0] blk;
    logic             wr;
    logic [SUB_W-1:0] sub;
  } cmd_t;

  // Sparse legality map of block/subblock pairs.
  function automatic logic pair_ok(input logic [BLK_W-1:0] b, input logic [SUB_W-1:0] s);
    logic ok;
    case (b)
      3'd1:             ok = (s <= 4'd4) || (s == 4'd6);
      3'd2, 3'd7:       ok = (s == 4'd0);
      3'd3, 3'd4, 3'd5: ok = (s <= 4'd1);
      default:          ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/spireg_framer.sv
module spireg_framer #(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sclk_s,
  input  logic              mosi_s,
  output logic              rise,
  output logic              unit_done,
  output logic [UNIT_W-1:0] unit_val
);

  localparam int CNT_W = $clog2(UNIT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(UNIT_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [UNIT_W-2:0] rx_sh;

  assign rise      = active && sclk_s && !sclk_q;
  assign unit_done = rise && (bit_cnt == LAST_BIT);
  assign unit_val  = {rx_sh, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (!active) begin
        bit_cnt <= '0;
      end else if (rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sh   <= {rx_sh[UNIT_W-3:0], mosi_s};
      end
    end
  end

endmodule

// File: rtl/spireg_shiftout.sv
module spireg_shiftout #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              shift,
  output logic              miso
);

  logic [WORD_W-1:0] out_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh <= '0;
    end else if (!active) begin
      out_sh <= '0;
    end else if (load) begin
      out_sh <= load_val;
    end else if (shift) begin
      out_sh <= {out_sh[WORD_W-2:0], 1'b0};
    end
  end

  assign miso = out_sh[WORD_W-1];

endmodule

// File: rtl/spireg_port.sv
module spireg_port
  import spireg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAD_BYTES   = 2,
  parameter int DATA_BYTES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_mosi,
  input  logic                      spi_cs_n,
  output logic                      spi_miso,
  output logic                      reg_req,
  output logic                      reg_we,
  output logic [BLK_W-1:0]          reg_blk,
  output logic [SUB_W-1:0]          reg_sub,
  output logic [UNIT_W-1:0]         reg_addr,
  output logic [UNIT_W*DATA_BYTES-1:0] reg_wdata,
  input  logic [UNIT_W*DATA_BYTES-1:0] reg_rdata,
  output logic                      err_flag
);

  localparam int WORD_W    = UNIT_W * DATA_BYTES;
  localparam int HDR       = 2;
  localparam int FRAME_MAX = HDR + PAD_BYTES + DATA_BYTES;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);
  localparam logic [IDX_W-1:0] IDX_CMD  = '0;
  localparam logic [IDX_W-1:0] IDX_REG  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_WD0  = IDX_W'(HDR);
  localparam logic [IDX_W-1:0] IDX_WDN  = IDX_W'(HDR + DATA_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_LOAD = IDX_W'(HDR + PAD_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_SAT  = '1;

  // Synchronized serial pins: {cs_n, mosi, sclk}
  logic [2:0] pins_s;
  spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_mosi, spi_sclk}),
    .q     (pins_s)
  );

  logic active;
  assign active = !pins_s[2];

  logic              rise;
  logic              unit_done;
  logic [UNIT_W-1:0] unit_val;
  spireg_framer #(.UNIT_W(UNIT_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .sclk_s    (pins_s[0]),
    .mosi_s    (pins_s[1]),
    .rise      (rise),
    .unit_done (unit_done),
    .unit_val  (unit_val)
  );

  logic [IDX_W-1:0]  idx;
  cmd_t              cmd_q;
  logic [UNIT_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              req_q;
  logic              we_q;
  logic              err_q;
  logic              legal;

  assign legal = pair_ok(cmd_q.blk, cmd_q.sub);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (!active) begin
      idx <= '0;
    end else if (unit_done && idx != IDX_SAT) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (active && unit_done) begin
        if (idx == IDX_CMD) begin
          cmd_q <= cmd_t'(unit_val);
        end
        if (idx == IDX_REG) begin
          addr_q <= unit_val;
          if (!cmd_q.wr) begin
            if (legal) begin
              req_q <= 1'b1;
              we_q  <= 1'b0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        if (cmd_q.wr && idx >= IDX_WD0 && idx <= IDX_WDN) begin
          wdata_q <= {wdata_q[WORD_W-UNIT_W-1:0], unit_val};
          if (idx == IDX_WDN) begin
            if (legal) begin
              req_q <= 1'b1;
              we_q  <= 1'b1;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  logic              rd_load;
  logic [WORD_W-1:0] rd_val;
  assign rd_load = active && unit_done && (idx == IDX_LOAD) && !cmd_q.wr;
  assign rd_val  = legal ? reg_rdata : '0;

  spireg_shiftout #(.WORD_W(WORD_W)) u_shiftout (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .load     (rd_load),
    .load_val (rd_val),
    .shift    (rise),
    .miso     (spi_miso)
  );

  assign reg_req   = req_q;
  assign reg_we    = we_q;
  assign reg_blk   = cmd_q.blk;
  assign reg_sub   = cmd_q.sub;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign err_flag  = err_q;

endmodule

// File: rtl/spireg_port_chk.sv
module spireg_port_chk
  import spireg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso,
  input logic             reg_req,
  input logic [BLK_W-1:0] reg_blk,
  input logic [SUB_W-1:0] reg_sub,
  input logic             err_flag
);

  logic [2:0] idle_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        idle_cnt <= '0;
    else if (!spi_cs_n)                idle_cnt <= '0;
    else if (idle_cnt != 3'd7)         idle_cnt <= idle_cnt + 1'b1;
  end

  // R8: strobe lasts a single cycle
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !reg_req);

  // R6: strobes only for legal pairs
  p_req_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> pair_ok(reg_blk, reg_sub));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R5: error rises only on an illegal pair
  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !pair_ok(reg_blk, reg_sub));

  // R7: quiet while deselected
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 3'd6) |-> (!reg_req && !spi_miso));

endmodule

bind spireg_port spireg_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_miso (spi_miso),
  .reg_req  (reg_req),
  .reg_blk  (reg_blk),
  .reg_sub  (reg_sub),
  .err_flag (err_flag)
);

// File: tb/test_spireg_port.sv
module test_spireg_port;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int WDOG       = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_miso;
  logic        reg_req;
  logic        reg_we;
  logic [2:0]  reg_blk;
  logic [3:0]  reg_sub;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        err_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spireg_port i_spireg_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_blk   (reg_blk),
    .reg_sub   (reg_sub),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .err_flag  (err_flag)
  );

  function automatic logic [31:0] rd_model(input logic [2:0] b, input logic [3:0] s, input logic [7:0] a);
    return {a, 1'b0, b, s, ~a, a ^ {b, 1'b1, s}};
  endfunction

  function automatic bit tb_legal(input int b, input int s);
    logic [15:0] mask;
    case (b)
      1:       mask = 16'h005F;
      2, 7:    mask = 16'h0001;
      3, 4, 5: mask = 16'h0003;
      default: mask = 16'h0000;
    endcase
    return mask[s];
  endfunction

  assign reg_rdata = rd_model(reg_blk, reg_sub, reg_addr);

  int          req_cnt = 0;
  logic        m_we;
  logic [2:0]  m_blk;
  logic [3:0]  m_sub;
  logic [7:0]  m_addr;
  logic [31:0] m_wdata;

  always @(negedge clk) begin
    if (reg_req) begin
      req_cnt = req_cnt + 1;
      m_we    = reg_we;
      m_blk   = reg_blk;
      m_sub   = reg_sub;
      m_addr  = reg_addr;
      m_wdata = reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sys_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      sys_wait(HALF);
      spi_sclk = 1'b1;
      rx[i] = spi_miso;
      sys_wait(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_open();
    spi_cs_n = 1'b0;
    sys_wait(HALF);
  endtask

  task automatic frame_close();
    sys_wait(HALF);
    spi_cs_n = 1'b1;
    sys_wait(12);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sys_wait(3);
    rst_n = 1'b1;
    sys_wait(3);
    chk(err_flag == 1'b0 && reg_req == 1'b0 && spi_miso == 1'b0, "R9 reset state",
        {29'd0, err_flag, reg_req, spi_miso}, 32'd0);
  endtask

  task automatic do_write(input int b, input int s, input logic [7:0] a, input logic [31:0] w, input int extra);
    logic [7:0] rx;
    frame_open();
    spi_xfer({3'(b), 1'b1, 4'(s)}, rx);
    spi_xfer(a, rx);
    for (int k = 3; k >= 0; k--) spi_xfer(w[k*8 +: 8], rx);
    for (int k = 0; k < extra; k++) spi_xfer(8'hA5, rx);
    frame_close();
  endtask

  task automatic do_read(input int b, input int s, input logic [7:0] a,
                         output logic [31:0] word, output logic [15:0] tail);
    logic [7:0] rx;
    frame_open();
    spi_xfer({3'(b), 1'b0, 4'(s)}, rx);
    spi_xfer(a, rx);
    spi_xfer(8'h00, rx);
    spi_xfer(8'h00, rx);
    for (int k = 3; k >= 0; k--) begin
      spi_xfer(8'h00, rx);
      word[k*8 +: 8] = rx;
    end
    spi_xfer(8'h00, rx);
    tail[15:8] = rx;
    spi_xfer(8'h00, rx);
    tail[7:0] = rx;
    frame_close();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] word;
    logic [15:0] tail;
    logic [7:0]  rx;
    int          c0;

    sys_wait(5);
    rst_n = 1'b1;
    sys_wait(3);
    chk(reg_req == 1'b0, "R9 req after reset", {31'd0, reg_req}, 32'd0);
    chk(err_flag == 1'b0, "R9 err after reset", {31'd0, err_flag}, 32'd0);
    chk(spi_miso == 1'b0, "R9 miso after reset", {31'd0, spi_miso}, 32'd0);

    // R7: abort after two data bytes, then a complete frame
    c0 = req_cnt;
    frame_open();
    spi_xfer(8'h30, rx);
    spi_xfer(8'h44, rx);
    spi_xfer(8'h11, rx);
    spi_xfer(8'h22, rx);
    frame_close();
    chk(req_cnt == c0, "R7 partial write dropped", 32'(req_cnt - c0), 32'd0);
    // R7: abort mid-byte
    frame_open();
    spi_xfer(8'h31, rx);
    for (int i = 0; i < 3; i++) begin
      spi_mosi = 1'b1;
      sys_wait(HALF);
      spi_sclk = 1'b1;
      sys_wait(HALF);
      spi_sclk = 1'b0;
    end
    frame_close();
    chk(req_cnt == c0, "R7 mid-byte abort dropped", 32'(req_cnt - c0), 32'd0);
    do_write(1, 2, 8'h5A, 32'hDEADBEEF, 0);
    chk(req_cnt == c0 + 1, "R7 restart strobe count", 32'(req_cnt - c0), 32'd1);
    chk(m_blk == 3'd1 && m_sub == 4'd2 && m_addr == 8'h5A && m_wdata == 32'hDEADBEEF,
        "R7 restart framing", m_wdata, 32'hDEADBEEF);

    // R10: extra bytes after a write frame
    c0 = req_cnt;
    do_write(3, 1, 8'h0F, 32'h01234567, 3);
    chk(req_cnt == c0 + 1, "R10 single strobe with trailing bytes", 32'(req_cnt - c0), 32'd1);
    chk(m_wdata == 32'h01234567, "R10 write word unaffected", m_wdata, 32'h01234567);

    // Sweep every block/subblock pair
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 16; s++) begin
        logic [7:0]  a;
        logic [31:0] w;
        bit          ok;
        ok = tb_legal(b, s);
        a  = 8'((b * 16 + s) * 29 + 5);
        w  = {a, ~a, 4'(s), 1'b1, 3'(b), a ^ 8'h3C};

        c0 = req_cnt;
        do_write(b, s, a, w, 0);
        if (ok) begin
          chk(req_cnt == c0 + 1, "R8 one write strobe", 32'(req_cnt - c0), 32'd1);
          chk(m_we == 1'b1 && m_blk == 3'(b) && m_sub == 4'(s), "R1 write command fields",
              {24'd0, m_blk, m_we, m_sub}, {24'd0, 3'(b), 1'b1, 4'(s)});
          chk(m_addr == a, "R2 write register byte", {24'd0, m_addr}, {24'd0, a});
          chk(m_wdata == w, "R3 write word", m_wdata, w);
          chk(err_flag == 1'b0, "R5 legal write no error", {31'd0, err_flag}, 32'd0);
        end else begin
          chk(req_cnt == c0, "R6 illegal write no strobe", 32'(req_cnt - c0), 32'd0);
          chk(err_flag == 1'b1, "R6 illegal write error", {31'd0, err_flag}, 32'd1);
          do_reset();
        end

        a  = a ^ 8'h55;
        c0 = req_cnt;
        do_read(b, s, a, word, tail);
        if (ok) begin
          chk(req_cnt == c0 + 1 && m_we == 1'b0, "R4 one read strobe", 32'(req_cnt - c0), 32'd1);
          chk(m_blk == 3'(b) && m_sub == 4'(s) && m_addr == a, "R1 read command fields",
              {21'd0, m_blk, m_sub, m_addr}, {21'd0, 3'(b), 4'(s), a});
          chk(word == rd_model(3'(b), 4'(s), a), "R4 read word", word, rd_model(3'(b), 4'(s), a));
          chk(tail == 16'd0, "R10 read past frame", {16'd0, tail}, 32'd0);
          chk(err_flag == 1'b0, "R5 legal read no error", {31'd0, err_flag}, 32'd0);
        end else begin
          chk(req_cnt == c0, "R6 illegal read no strobe", 32'(req_cnt - c0), 32'd0);
          chk(word == 32'd0, "R6 illegal read zeros", word, 32'd0);
          chk(err_flag == 1'b1, "R6 illegal read error", {31'd0, err_flag}, 32'd1);
          do_reset();
        end
      end
    end

    // R6: flag stays set across a later legal access
    do_write(0, 0, 8'h00, 32'h0, 0);
    do_write(2, 0, 8'h10, 32'h12345678, 0);
    chk(err_flag == 1'b1, "R6 error sticky", {31'd0, err_flag}, 32'd1);
    chk(spi_miso == 1'b0 && reg_req == 1'b0, "R7 idle outputs quiet",
        {30'd0, spi_miso, reg_req}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule